// File: doc/BRIEF.md
# Interrupt Priority and Vector Dispatch

This block decides, once per clock, whether control must leave the running program, and computes where it goes. It watches four asynchronous request lines (device, timer, interprocessor, machine check) and a synchronous exception strobe with a cause code and an optional firmware-call number. Each cycle the current PC, a 3-bit interrupt priority level, the privileged firmware-mode flag and the firmware base address are sampled.

When an event is taken, the block pulses `take_o` for one cycle. In the same cycle it presents three values: the saved return address (the PC with bit 0 carrying the prior privileged flag), the entry PC (firmware base plus a vector offset) and an info byte. The pipeline around it uses `take_o` / `priv_set_o` to redirect fetch and to enter privileged mode. Requests are level signals owned by their sources and are never latched here. The priority level masks request classes in a cumulative ladder. Firmware calls land in two regions, each of 64-byte slots.

Top module: `irq_vector_dispatch`

## Requirements
- R1: After reset `take_o`, `priv_set_o` and `err_o` are 0, and `exc_addr_o`, `new_pc_o` and `info_o` are 0.
- R2: While `priv_i` is 1, no asynchronous request is taken.
- R3: `req_i` bit 0 is device, bit 1 timer, bit 2 interprocessor, bit 3 machine check. Request bit k is allowed only when `ipl_i` < 4+k: levels 0..3 allow all four classes, level 4 blocks device, level 5 also blocks timer, level 6 allows only machine check, and level 7 blocks all.
- R4: Among allowed pending requests the higher bit index wins: machine check, then interprocessor, then timer, then device.
- R5: The asynchronous vector offsets are machine check 0x080, interprocessor 0x100, timer 0x180 and device 0x200.
- R6: `exc_code_i` encodes 0 reset (offset 0x000), 1 memory fault (0x280), 2 unaligned (0x300), 3 illegal opcode (0x380), 4 arithmetic (0x400), 5 FP disabled (0x480) and 6 firmware call.
- R7: A firmware call with number n (`call_num_i`) vectors to 0x2000 + (n-0x80)*64 if bit 7 of n is set, otherwise to 0x1000 + n*64.
- R8: Inputs sampled at a clock edge produce outputs after that edge. On a take, `exc_addr_o` = `pc_i` with bit 0 ORed with `priv_i` (PC is 4-byte aligned) and `new_pc_o` = `fw_base_i` + offset. `priv_set_o` pulses with `take_o`. Between takes, both address outputs hold.
- R9: `info_o` is set to 0 on an interrupt or a non-call exception, and to n on a firmware call.
- R10: A valid synchronous exception wins over any request in the same cycle and is taken even in privileged mode.
- R11: `take_o` is high for exactly one cycle. In the cycle after a take all inputs are ignored (no take, no error), and a request dropped before being taken leaves no trace.
- R12: A valid exception with code 7..15 pulses `err_o` for one cycle, with no take and no change to `exc_addr_o`, `new_pc_o` or `info_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Request levels: device, timer, interprocessor, machine check (bits 0..3) |
| exc_valid_i | input | 1 | Synchronous exception present |
| exc_code_i | input | 4 | Exception cause code |
| call_num_i | input | 8 | Firmware call number |
| pc_i | input | PC_W | Current PC |
| ipl_i | input | 3 | Interrupt priority level |
| priv_i | input | 1 | Privileged firmware mode active |
| fw_base_i | input | PC_W | Firmware base address |
| take_o | output | 1 | One-cycle pulse: event taken |
| priv_set_o | output | 1 | One-cycle pulse: enter privileged mode |
| err_o | output | 1 | One-cycle pulse: unknown exception code |
| exc_addr_o | output | PC_W | Saved return address |
| new_pc_o | output | PC_W | Entry PC |
| info_o | output | 8 | Error/call info byte |

## Verification
All decisions are registered once, so a wrong mask, priority choice or offset shows at the ports one cycle after the stimulus: either a missing or extra `take_o`, or a wrong `new_pc_o`. A stuck take-suppression flag appears as a take in two consecutive cycles, or as a held request never being taken again. The bench sweeps every level against every request pattern, each code and both call regions. It compares all outputs against a behavioural model on every clock.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
    localparam int N_REQ    = 4;
    localparam int IDX_W    = $clog2(N_REQ);
    localparam int IPL_W    = 3;
    localparam int CODE_W   = 4;
    localparam int NUM_W    = 8;
    localparam int OFF_W    = 14;
    localparam int OPEN_LVL = 4;
    localparam int VEC_STEP = 'h80;
    localparam int CALL_LO  = 'h1000;
    localparam int CALL_HI  = 'h2000;
    localparam int CALL_SH  = 6;

    typedef enum logic [CODE_W-1:0] {
        EC_RESET  = 4'd0,
        EC_MFAULT = 4'd1,
        EC_UNALN  = 4'd2,
        EC_ILLOP  = 4'd3,
        EC_ARITH  = 4'd4,
        EC_FPDIS  = 4'd5,
        EC_CALL   = 4'd6
    } exc_code_e;
endpackage

// File: rtl/irqvec_grant.sv
module irqvec_grant
    import irqvec_pkg::*;
(
    input  logic [N_REQ-1:0] req_i,
    input  logic [IPL_W-1:0] ipl_i,
    input  logic             priv_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N_REQ-1:0] open_lvl;

    generate
        for (genvar k = 0; k < N_REQ; k++) begin : g_ladder
            assign open_lvl[k] = (int'(ipl_i) < OPEN_LVL + k);
        end
    endgenerate

    logic [N_REQ-1:0] live;
    assign live = req_i & open_lvl & {N_REQ{~priv_i}};

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = 0; k < N_REQ; k++) begin
            if (live[k]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/irqvec_offset.sv
module irqvec_offset
    import irqvec_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [NUM_W-1:0]  num_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              known_o,
    output logic [OFF_W-1:0]  sync_off_o,
    output logic [OFF_W-1:0]  async_off_o
);
    logic [OFF_W-1:0] call_off;

    always_comb begin
        call_off = OFF_W'((num_i[NUM_W-1] ? CALL_HI : CALL_LO)
                   + (int'(num_i[NUM_W-2:0]) << CALL_SH));
    end

    always_comb begin
        known_o    = 1'b1;
        sync_off_o = '0;
        case (code_i)
            EC_RESET:  sync_off_o = '0;
            EC_MFAULT, EC_UNALN, EC_ILLOP, EC_ARITH, EC_FPDIS:
                sync_off_o = OFF_W'((int'(code_i) + N_REQ) * VEC_STEP);
            EC_CALL:   sync_off_o = call_off;
            default:   known_o = 1'b0;
        endcase
    end

    assign async_off_o = OFF_W'((N_REQ - int'(idx_i)) * VEC_STEP);
endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
    import irqvec_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          req_i,
    input  logic                exc_valid_i,
    input  logic [3:0]          exc_code_i,
    input  logic [7:0]          call_num_i,
    input  logic [PC_W-1:0]     pc_i,
    input  logic [2:0]          ipl_i,
    input  logic                priv_i,
    input  logic [PC_W-1:0]     fw_base_i,
    output logic                take_o,
    output logic                priv_set_o,
    output logic                err_o,
    output logic [PC_W-1:0]     exc_addr_o,
    output logic [PC_W-1:0]     new_pc_o,
    output logic [7:0]          info_o
);
    typedef struct packed {
        logic            take;
        logic            err;
        logic [PC_W-1:0] addr;
        logic [PC_W-1:0] npc;
        logic [NUM_W-1:0] info;
    } disp_st_t;

    disp_st_t st_d, st_q;

    logic             async_any;
    logic [IDX_W-1:0] async_idx;
    logic             code_known;
    logic [OFF_W-1:0] sync_off, async_off;

    irqvec_grant u_grant (
        .req_i  (req_i),
        .ipl_i  (ipl_i),
        .priv_i (priv_i),
        .any_o  (async_any),
        .idx_o  (async_idx)
    );

    irqvec_offset u_offset (
        .code_i      (exc_code_i),
        .num_i       (call_num_i),
        .idx_i       (async_idx),
        .known_o     (code_known),
        .sync_off_o  (sync_off),
        .async_off_o (async_off)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.err  = 1'b0;
        if (!st_q.take) begin
            if (exc_valid_i) begin
                if (code_known) begin
                    st_d.take = 1'b1;
                    st_d.addr = pc_i | PC_W'(priv_i);
                    st_d.npc  = fw_base_i + PC_W'(sync_off);
                    st_d.info = (exc_code_i == EC_CALL) ? call_num_i : '0;
                end else begin
                    st_d.err = 1'b1;
                end
            end else if (async_any) begin
                st_d.take = 1'b1;
                st_d.addr = pc_i | PC_W'(priv_i);
                st_d.npc  = fw_base_i + PC_W'(async_off);
                st_d.info = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o     = st_q.take;
    assign priv_set_o = st_q.take;
    assign err_o      = st_q.err;
    assign exc_addr_o = st_q.addr;
    assign new_pc_o   = st_q.npc;
    assign info_o     = st_q.info;

    // R2
    priv_blocks_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid_i && priv_i) |=> !take_o);

    // R3
    ipl_top_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid_i && ipl_i == 3'd7) |=> !take_o);

    // R10
    sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && exc_code_i <= 4'd6 && !take_o) |=> take_o);

    // R11
    take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (!take_o && !err_o));

    // R12
    err_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(new_pc_o) && $stable(exc_addr_o) && !take_o));

    // R8
    addr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (exc_addr_o[0] == ($past(priv_i) | $past(pc_i[0]))));
endmodule

// File: tb/irq_vector_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_vector_dispatch_tb_top;
    localparam int PC_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]      req = '0;
    logic            ev = 1'b0;
    logic [3:0]      code = '0;
    logic [7:0]      num = '0;
    logic [PC_W-1:0] pc = '0;
    logic [2:0]      ipl = '0;
    logic            priv = 1'b0;
    logic [PC_W-1:0] base = '0;

    logic            take, pset, err;
    logic [PC_W-1:0] eaddr, npc;
    logic [7:0]      info;

    always #2.5 clk = ~clk;

    irq_vector_dispatch #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .exc_valid_i(ev),
        .exc_code_i(code), .call_num_i(num), .pc_i(pc), .ipl_i(ipl),
        .priv_i(priv), .fw_base_i(base), .take_o(take), .priv_set_o(pset),
        .err_o(err), .exc_addr_o(eaddr), .new_pc_o(npc), .info_o(info)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    bit          e_take = 0, e_err = 0, m_prev = 0;
    logic [31:0] e_addr = '0, e_npc = '0;
    logic [7:0]  e_info = '0;

    task automatic cmp(string tag, string what, longint act, longint exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model();
        int off;
        int pick;
        e_take = 0; e_err = 0; off = 0; pick = -1;
        if (!m_prev) begin
            if (ev) begin
                if (code <= 6) begin
                    e_take = 1;
                    if (code == 0) off = 0;
                    else if (code == 6)
                        off = (num >= 128) ? 'h2000 + (num - 128) * 64 : 'h1000 + num * 64;
                    else off = 'h280 + (code - 1) * 'h80;
                    e_info = (code == 6) ? num : 8'd0;
                end else e_err = 1;
            end else if (!priv) begin
                if (req[3] && ipl < 7)      pick = 'h080;
                else if (req[2] && ipl < 6) pick = 'h100;
                else if (req[1] && ipl < 5) pick = 'h180;
                else if (req[0] && ipl < 4) pick = 'h200;
                if (pick >= 0) begin
                    e_take = 1; off = pick; e_info = 0;
                end
            end
        end
        if (e_take) begin
            e_addr = pc | {31'd0, priv};
            e_npc  = base + off;
        end
        m_prev = e_take;
    endtask

    task automatic step(string tag, logic [3:0] r, logic v, logic [3:0] c,
                        logic [7:0] n, logic [31:0] p, logic [2:0] l,
                        logic pr, logic [31:0] b);
        req = r; ev = v; code = c; num = n; pc = p; ipl = l; priv = pr; base = b;
        model();
        @(posedge clk);
        @(negedge clk);
        vectors++;
        cmp(tag, "take", take, e_take);
        cmp(tag, "priv_set", pset, e_take);
        cmp(tag, "err", err, e_err);
        cmp(tag, "exc_addr", eaddr, e_addr);
        cmp(tag, "new_pc", npc, e_npc);
        cmp(tag, "info", info, e_info);
    endtask

    task automatic idle(string tag);
        step(tag, 4'h0, 0, 4'h0, 8'h0, 32'h0000_4000, 3'd0, 0, 32'h8000_0000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        vectors++;
        // R1 reset state
        cmp("R1", "take", take, 0);
        cmp("R1", "err", err, 0);
        cmp("R1", "new_pc", npc, 0);
        cmp("R1", "exc_addr", eaddr, 0);
        cmp("R1", "info", info, 0);
        rst_n = 1'b1;
        idle("R1");

        // R5 each class alone, level 0
        step("R5", 4'b0001, 0, 0, 0, 32'h100, 3'd0, 0, 32'h8000_0000); idle("R5");
        step("R5", 4'b0010, 0, 0, 0, 32'h104, 3'd0, 0, 32'h8000_0000); idle("R5");
        step("R5", 4'b0100, 0, 0, 0, 32'h108, 3'd0, 0, 32'h8000_0000); idle("R5");
        step("R5", 4'b1000, 0, 0, 0, 32'h10c, 3'd0, 0, 32'h8000_0000); idle("R5");

        // R3 R4 full sweep of level x request pattern
        for (int l = 0; l < 8; l++) begin
            for (int r = 0; r < 16; r++) begin
                step("R3_R4", 4'(r), 0, 0, 0, 32'h2000 + 32'(r*4), 3'(l), 0, 32'h0010_0000);
                idle("R3_R4");
            end
        end

        // R2 privileged mode blocks all requests
        step("R2", 4'hf, 0, 0, 0, 32'h300, 3'd0, 1, 32'h8000_0000);
        step("R2", 4'h8, 0, 0, 0, 32'h304, 3'd0, 1, 32'h8000_0000);

        // R6 every known code; R9 info zero
        for (int c = 0; c < 6; c++) begin
            step("R6", 4'h0, 1, 4'(c), 8'h55, 32'h400, 3'd0, 0, 32'h0200_0000);
            idle("R9");
        end

        // R7 firmware call both regions
        step("R7", 4'h0, 1, 4'd6, 8'h00, 32'h500, 3'd0, 0, 32'h0300_0000); idle("R7");
        step("R7", 4'h0, 1, 4'd6, 8'h7f, 32'h504, 3'd0, 0, 32'h0300_0000); idle("R7");
        step("R7", 4'h0, 1, 4'd6, 8'h80, 32'h508, 3'd0, 1, 32'h0300_0000); idle("R7");
        step("R7", 4'h0, 1, 4'd6, 8'hff, 32'h50c, 3'd0, 0, 32'h0300_0000); idle("R7");
        step("R7", 4'h0, 1, 4'd6, 8'h83, 32'h510, 3'd0, 0, 32'h0300_0000); idle("R7");

        // R8 priv flag recorded in bit 0 on synchronous entry in priv mode
        step("R8", 4'h0, 1, 4'd4, 8'h0, 32'h0000_abcc, 3'd7, 1, 32'h0400_0000); idle("R8");

        // R10 sync beats async, and works at level 7 / priv
        step("R10", 4'hf, 1, 4'd1, 8'h0, 32'h600, 3'd0, 0, 32'h0500_0000); idle("R10");
        step("R10", 4'hf, 1, 4'd3, 8'h0, 32'h604, 3'd7, 1, 32'h0500_0000); idle("R10");

        // R11 held request: taken, suppressed, taken again
        step("R11", 4'h2, 0, 0, 0, 32'h700, 3'd0, 0, 32'h0600_0000);
        step("R11", 4'h2, 0, 0, 0, 32'h704, 3'd0, 0, 32'h0600_0000);
        step("R11", 4'h2, 0, 0, 0, 32'h708, 3'd0, 0, 32'h0600_0000);
        // R11 request during suppression cycle dropped -> no trace
        step("R11", 4'h0, 1, 4'd2, 0, 32'h70c, 3'd0, 0, 32'h0600_0000);
        step("R11", 4'h0, 0, 0, 0, 32'h710, 3'd0, 0, 32'h0600_0000);
        idle("R11");

        // R12 unknown codes
        for (int c = 7; c < 16; c++) begin
            step("R12", 4'hf, 1, 4'(c), 8'h12, 32'h800, 3'd0, 0, 32'h0700_0000);
        end
        idle("R12");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule